// File: doc/BRIEF.md
# Scripted AHB-Lite Test Master

This block is a bus master that plays a fixed list of single AHB-Lite transfers onto a slave, with no processor involved. It is used to bring up a memory slave and to watch the pipelined bus at work. The list has seven word-sized accesses to two locations. One write places a known pattern. The read that follows it at once goes to the other location, so that the bench can see the address phase of one access overlap the data phase of the one before it. A later read of the written word must return the pattern.

The core is a four-state sequencer. `ST_BOOT` is a single idle cycle after reset. It moves to `ST_ISSUE`, which presents one command per accepted address phase. After the last address is accepted it moves to `ST_DRAIN`, which waits out the final data phase. It then moves to `ST_FINISH`, which it never leaves. The named transitions are: boot-to-issue, which is unconditional; issue-advance, taken on `hready` high while commands remain; issue-to-drain, taken on `hready` high on the last command; and drain-to-finish, taken on `hready` high. A separate data-phase tracker drives the write data, captures read data and records error responses.

Top module: `ahbl_script_master`

## Requirements
- R1: While `hresetn` is low, `htrans` is IDLE (2'b00), `done` is 0, `last_rdata` is 0 and `err_seen` is 0.
- R2: After reset the master issues exactly seven address phases, in this order. Read C200_0000. Read C200_0010. Write C200_0000. Read C200_0010. Read C200_0010. Read C200_0000. Read C200_0010. `hwrite` is 1 for a write and 0 for a read.
- R3: Every address phase has `htrans` = NONSEQ (2'b10), `hburst` = SINGLE (3'b000), `hsize` = word (3'b010, meaning 2^2 bytes) and `hprot` = 4'b0011.
- R4: While `hready` is low, `haddr`, `htrans` and `hwrite` keep their values from the previous cycle.
- R5: The write data 0x00001234 appears on `hwdata` only in the data phase that follows the write's address phase. In every other cycle, including the write's own address phase and all read data phases, `hwdata` is zero.
- R6: `last_rdata` takes the value of `hrdata` on the rising edge that ends a read data phase with `hready` high. It does not change while `hready` is low. The sixth access returns 0x00001234 from a correct memory.
- R7: Once the last data phase has completed, `done` is 1 and `htrans` is IDLE, and both stay that way until reset.
- R8: An ERROR response (`hresp` = 1) during a data phase sets `err_seen`. The flag stays set until reset, and the script still runs to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock, rising edge active |
| hresetn | input | 1 | Asynchronous reset, active low |
| hready | input | 1 | High when the current data phase completes |
| hrdata | input | 32 | Read data from the slave |
| hresp | input | 1 | Slave response, 1 = ERROR |
| haddr | output | 32 | Transfer address |
| htrans | output | 2 | Transfer type, IDLE or NONSEQ |
| hwrite | output | 1 | 1 = write, 0 = read |
| hsize | output | 3 | Transfer size code |
| hburst | output | 3 | Burst type, always SINGLE |
| hprot | output | 4 | Protection code |
| hwdata | output | 32 | Write data, valid in the write data phase |
| done | output | 1 | High once the script has completed |
| last_rdata | output | 32 | Most recent captured read data |
| err_seen | output | 1 | Sticky ERROR response flag |

## Verification
The assertions rely on the slave obeying the AHB-Lite handshake. `hready` may be low only during a data phase that is in progress. An ERROR response must be the usual two-cycle pattern, with `hresp` high across a low and then a high `hready`. The bench slave holds `hready` high whenever no data phase is open. It inserts a fixed pattern of zero to three wait states per access in one run, and a two-cycle ERROR on the write in another. Its word memory is decoded from address bits 5:2, so every stall and error stays within these rules.

// File: rtl/ahbl_scr_pkg.sv
package ahbl_scr_pkg;
    localparam int SCR_LEN = 7;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [2:0] HB_SINGLE = 3'b000;
    localparam logic [2:0] HS_WORD   = 3'b010;
    localparam logic [3:0] HP_DATA   = 4'b0011;

    // bit i set: command i is a write / targets the high word
    localparam logic [SCR_LEN-1:0] SCR_WR_MASK = 7'b0000100;
    localparam logic [SCR_LEN-1:0] SCR_HI_MASK = 7'b1011010;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } scr_state_e;
endpackage

// File: rtl/ahbl_scr_rom.sv
module ahbl_scr_rom
    import ahbl_scr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hC200_0000,
    parameter logic [ADDR_W-1:0] HI_STEP   = 'h10,
    parameter logic [DATA_W-1:0] WR_VALUE  = 'h1234,
    localparam int IDX_W = $clog2(SCR_LEN)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);
    logic              tbl_wr    [SCR_LEN];
    logic [ADDR_W-1:0] tbl_addr  [SCR_LEN];
    logic [DATA_W-1:0] tbl_wdata [SCR_LEN];

    for (genvar i = 0; i < SCR_LEN; i++) begin : g_entry
        assign tbl_wr[i]    = SCR_WR_MASK[i];
        assign tbl_addr[i]  = SCR_HI_MASK[i] ? (BASE_ADDR + HI_STEP) : BASE_ADDR;
        assign tbl_wdata[i] = SCR_WR_MASK[i] ? WR_VALUE : '0;
    end

    always_comb begin
        cmd_wr    = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        for (int k = 0; k < SCR_LEN; k++) begin
            if (idx == IDX_W'(k)) begin
                cmd_wr    = tbl_wr[k];
                cmd_addr  = tbl_addr[k];
                cmd_wdata = tbl_wdata[k];
            end
        end
    end
endmodule

// File: rtl/ahbl_scr_dphase.sv
module ahbl_scr_dphase #(
    parameter int DATA_W = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hready,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hresp,
    input  logic              accept,
    input  logic              accept_wr,
    input  logic [DATA_W-1:0] accept_wdata,
    output logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] last_rdata,
    output logic              err_seen
);
    logic              dp_valid;
    logic              dp_wr;
    logic [DATA_W-1:0] dp_wdata;

    // data phase register: advances only when the bus moves on
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            dp_valid <= 1'b0;
            dp_wr    <= 1'b0;
            dp_wdata <= '0;
        end else if (hready) begin
            dp_valid <= accept;
            dp_wr    <= accept & accept_wr;
            dp_wdata <= accept_wdata;
        end
    end

    assign hwdata = (dp_valid && dp_wr) ? dp_wdata : '0;

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            last_rdata <= '0;
            err_seen   <= 1'b0;
        end else begin
            if (hready && dp_valid && !dp_wr) last_rdata <= hrdata;
            if (dp_valid && hresp)            err_seen   <= 1'b1;
        end
    end
endmodule

// File: rtl/ahbl_script_master.sv
module ahbl_script_master
    import ahbl_scr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hC200_0000,
    parameter logic [ADDR_W-1:0] HI_STEP   = 'h10,
    parameter logic [DATA_W-1:0] WR_VALUE  = 'h1234
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hready,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hresp,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst,
    output logic [3:0]        hprot,
    output logic [DATA_W-1:0] hwdata,
    output logic              done,
    output logic [DATA_W-1:0] last_rdata,
    output logic              err_seen
);
    localparam int IDX_W = $clog2(SCR_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCR_LEN - 1);

    scr_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              accept;

    ahbl_scr_rom #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
        .HI_STEP(HI_STEP), .WR_VALUE(WR_VALUE)
    ) u_rom (
        .idx(idx), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:   state_nx = ST_ISSUE;
            ST_ISSUE:  if (hready && idx == LAST_IDX) state_nx = ST_DRAIN;
            ST_DRAIN:  if (hready) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_FINISH;
            default:   state_nx = ST_BOOT;
        endcase
    end

    // state register and command pointer
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            state <= ST_BOOT;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_ISSUE && hready && idx != LAST_IDX) idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        haddr  = '0;
        htrans = HT_IDLE;
        hwrite = 1'b0;
        done   = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_BOOT, ST_DRAIN: ;
            ST_ISSUE: begin
                haddr  = cmd_addr;
                htrans = HT_NONSEQ;
                hwrite = cmd_wr;
                accept = hready;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign hsize  = HS_WORD;
    assign hburst = HB_SINGLE;
    assign hprot  = HP_DATA;

    ahbl_scr_dphase #(.DATA_W(DATA_W)) u_dphase (
        .hclk(hclk), .hresetn(hresetn), .hready(hready), .hrdata(hrdata),
        .hresp(hresp), .accept(accept), .accept_wr(cmd_wr),
        .accept_wdata(cmd_wdata), .hwdata(hwdata), .last_rdata(last_rdata),
        .err_seen(err_seen)
    );
endmodule

// File: rtl/ahbl_script_master_chk.sv
module ahbl_script_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hready,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic              hwrite,
    input logic [2:0]        hsize,
    input logic [2:0]        hburst,
    input logic [DATA_W-1:0] hwdata,
    input logic              done,
    input logic [DATA_W-1:0] last_rdata,
    input logic              err_seen
);
    assert_attr_R3: assert property (@(posedge hclk) disable iff (!hresetn)
        (htrans != 2'b00) |-> (htrans == 2'b10 && hsize == 3'b010 && hburst == 3'b000));

    assert_hold_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hready && htrans != 2'b00) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

    assert_rd_no_wdata_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        (htrans == 2'b10 && hready && !hwrite) |=> (hwdata == '0));

    assert_wr_wdata_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        (htrans == 2'b10 && hready && hwrite) |=> (hwdata == DATA_W'(32'h1234)));

    assert_rdata_hold_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> $stable(last_rdata));

    assert_done_sticky_R7: assert property (@(posedge hclk) disable iff (!hresetn)
        done |=> (done && htrans == 2'b00));

    assert_err_sticky_R8: assert property (@(posedge hclk) disable iff (!hresetn)
        err_seen |=> err_seen);
endmodule

bind ahbl_script_master ahbl_script_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .hclk(hclk), .hresetn(hresetn), .hready(hready), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .done(done), .last_rdata(last_rdata), .err_seen(err_seen)
);

// File: tb/test_ahbl_script_master.sv
`timescale 1ns/1ps
module test_ahbl_script_master;
    logic        hclk = 1'b0;
    logic        hresetn = 1'b1;
    logic        hready;
    logic [31:0] hrdata;
    logic        hresp;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize, hburst;
    logic [3:0]  hprot;
    logic [31:0] hwdata;
    logic        done;
    logic [31:0] last_rdata;
    logic        err_seen;

    int n_chk = 0;
    int n_bad = 0;

    always #2 hclk = ~hclk;

    ahbl_script_master i_ahbl_script_master (
        .hclk(hclk), .hresetn(hresetn), .hready(hready), .hrdata(hrdata),
        .hresp(hresp), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hburst(hburst), .hprot(hprot), .hwdata(hwdata),
        .done(done), .last_rdata(last_rdata), .err_seen(err_seen)
    );

    // expected script: address, write flag, expected read value, read checked
    localparam logic [31:0] EXP_ADDR [7] = '{32'hC200_0000, 32'hC200_0010, 32'hC200_0000,
        32'hC200_0010, 32'hC200_0010, 32'hC200_0000, 32'hC200_0010};
    localparam logic        EXP_WR   [7] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] EXP_RD   [7] = '{32'hA5A5_0000, 32'h5A5A_0010, 32'h0,
        32'h0, 32'h5A5A_0010, 32'h0000_1234, 32'h5A5A_0010};
    localparam logic        EXP_CHK  [7] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    // ---------------- slave model ----------------
    int          mode;           // 0 no wait, 1 wait states, 2 error on write
    logic [31:0] mem [16];
    logic        s_act, s_wr;
    logic [3:0]  s_idx;
    int          s_no, s_cur, s_wait;

    always_comb begin
        hready = !(s_act && s_wait != 0);
        hresp  = s_act && mode == 2 && s_cur == 2;
        hrdata = (s_act && !s_wr) ? mem[s_idx] : 32'h0;
    end

    always @(posedge hclk) begin
        if (!hresetn) begin
            s_act <= 1'b0; s_wr <= 1'b0; s_idx <= '0; s_no <= 0; s_cur <= 0; s_wait <= 0;
            for (int k = 0; k < 16; k++) mem[k] <= 32'h0;
            mem[0] <= 32'hA5A5_0000;
            mem[4] <= 32'h5A5A_0010;
        end else if (!hready) begin
            s_wait <= s_wait - 1;
        end else begin
            if (s_act && s_wr) mem[s_idx] <= hwdata;
            if (htrans == 2'b10) begin
                s_act  <= 1'b1;
                s_wr   <= hwrite;
                s_idx  <= haddr[5:2];
                s_cur  <= s_no;
                s_no   <= s_no + 1;
                s_wait <= (mode == 1) ? ((s_no * 3) % 4) : ((mode == 2 && s_no == 2) ? 1 : 0);
            end else begin
                s_act <= 1'b0;
            end
        end
    end

    // ---------------- bus monitor ----------------
    int          m_cnt;
    logic [31:0] m_addr [8];
    logic        m_wr   [8];
    logic        m_attr_ok [8];
    logic [31:0] m_wd_dp [8];
    logic [31:0] m_wd_ap [8];
    logic [31:0] m_rd   [8];
    int          m_dp, m_cap;
    int          m_hold_bad, m_rd_move;
    logic        p_ready;
    logic [31:0] p_addr, p_rd;
    logic [1:0]  p_trans;
    logic        p_wr;

    always @(negedge hclk) begin
        if (!hresetn) begin
            m_cnt = 0; m_dp = -1; m_cap = -1; m_hold_bad = 0; m_rd_move = 0; p_ready = 1'b1;
        end else begin
            if (m_cap >= 0) begin m_rd[m_cap] = last_rdata; m_cap = -1; end
            if (!p_ready && (haddr != p_addr || htrans != p_trans || hwrite != p_wr))
                m_hold_bad++;
            if (!p_ready && last_rdata != p_rd) m_rd_move++;
            if (m_dp >= 0 && hready) begin
                m_wd_dp[m_dp] = hwdata;
                if (!m_wr[m_dp]) m_cap = m_dp;
                m_dp = -1;
            end
            if (htrans == 2'b10 && hready && m_cnt < 8) begin
                m_addr[m_cnt]    = haddr;
                m_wr[m_cnt]      = hwrite;
                m_attr_ok[m_cnt] = (hsize == 3'b010 && hburst == 3'b000 && hprot == 4'b0011);
                m_wd_ap[m_cnt]   = hwdata;
                m_dp = m_cnt;
                m_cnt++;
            end
        end
        p_ready = hready; p_addr = haddr; p_trans = htrans; p_wr = hwrite; p_rd = last_rdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_script(input int m);
        int cyc;
        mode = m;
        hresetn = 1'b0;
        repeat (3) @(posedge hclk);
        @(negedge hclk);
        chk("R1 htrans in reset", 32'(htrans), 32'h0);
        chk("R1 done in reset", 32'(done), 32'h0);
        chk("R1 last_rdata in reset", last_rdata, 32'h0);
        chk("R1 err_seen in reset", 32'(err_seen), 32'h0);
        hresetn = 1'b1;
        cyc = 0;
        while (!done && cyc < 400) begin @(negedge hclk); cyc++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog: actual done=0 expected done=1 (mode %0d)", m);
        end
        repeat (4) @(negedge hclk);
        chk("R2 address phase count", 32'(m_cnt), 32'd7);
        for (int i = 0; i < 7; i++) begin
            chk("R2 address", m_addr[i], EXP_ADDR[i]);
            chk("R2 direction", 32'(m_wr[i]), 32'(EXP_WR[i]));
            chk("R3 size/burst/prot", 32'(m_attr_ok[i]), 32'h1);
            chk("R5 hwdata in data phase", m_wd_dp[i], EXP_WR[i] ? 32'h1234 : 32'h0);
            if (EXP_CHK[i] && !EXP_WR[i]) chk("R6 read data", m_rd[i], EXP_RD[i]);
        end
        chk("R5 hwdata in write address phase", m_wd_ap[2], 32'h0);
        chk("R4 control held during stall", 32'(m_hold_bad), 32'h0);
        chk("R6 last_rdata steady during stall", 32'(m_rd_move), 32'h0);
        chk("R7 done stays high", 32'(done), 32'h1);
        chk("R7 idle after script", 32'(htrans), 32'h0);
        chk("R8 error flag", 32'(err_seen), (m == 2) ? 32'h1 : 32'h0);
    endtask

    initial begin
        mode = 0;
        #1;
        run_script(0);
        run_script(1);
        run_script(2);
        // R8: flag remains set long after the error, cleared only by reset
        repeat (20) @(negedge hclk);
        chk("R8 error flag sticky", 32'(err_seen), 32'h1);
        hresetn = 1'b0;
        @(negedge hclk);
        chk("R8 error flag cleared by reset", 32'(err_seen), 32'h0);
        chk("R1 done cleared by reset", 32'(done), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule